// File: doc/BRIEF.md
# Sorted Two-Stream Merge with Duplicate Removal

This block takes two integer streams, each already sorted from largest to smallest, and merges them into one output stream in the same descending order. A value present at the head of both inputs at the same moment appears on the output only once. Each input and the output use a valid/ready handshake.

One head register sits behind each input. The block compares the two heads only after both are loaded, so reads always block: a missing value on one side stalls the merge and does not change its decision. On each output transfer the larger head is emitted. Equal heads produce one output value. After the transfer, only the side or sides whose head was used are refilled. While the output is stalled, the comparison result and the presented value stay fixed.

The block suits merge-style producers in a dataflow pipeline, where several ordered sequences must be combined without repeats. Stream generation and end-of-stream handling are left to the surrounding logic.

Top module: `sorted_merge_dedup`

## Requirements
- R1: While reset is applied, and after it is released, both heads are empty: out_valid is 0, and a_ready and b_ready are 1 once the internal reset has been released.
- R2: out_valid stays 0 until both heads hold a value. A value waiting on one input alone never produces an output.
- R3: When both heads are loaded and head A is greater than head B, out_data shows head A. A transfer on the output then consumes only head A: a_ready is 1 and b_ready is 0.
- R4: When head B is greater than head A, out_data shows head B. A transfer on the output then consumes only head B: b_ready is 1 and a_ready is 0.
- R5: When the heads are equal, the value is emitted exactly once, and that transfer consumes both heads: a_ready and b_ready are both 1.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change on the next cycle.
- R7: An input's ready is 1 only when its head is empty or is being consumed by an output transfer in the same cycle. A full head that is not consumed holds its value.
- R8: For two strictly descending input streams, each ending with the value 0, the output is the descending union of both streams with every value appearing once. This holds for any pattern of valid and ready gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| a_valid | input | 1 | Stream A value offered |
| a_data | input | W | Stream A value, unsigned |
| a_ready | output | 1 | Stream A value accepted this cycle when a_valid is 1 |
| b_valid | input | 1 | Stream B value offered |
| b_data | input | W | Stream B value, unsigned |
| b_ready | output | 1 | Stream B value accepted this cycle when b_valid is 1 |
| out_valid | output | 1 | Merged value presented |
| out_data | output | W | Merged value, unsigned |
| out_ready | input | 1 | Downstream accepts out_data |

## Verification
The assertions check these properties on every cycle:
- The output waits for both heads.
- The presented value is never below either head.
- A stalled output holds its value.
- Equal heads release both inputs on a transfer, and unequal heads release exactly one.
- A full head that is not consumed keeps its value.

Only the bench's scenarios can show that the merged sequence as a whole is correct. That means every value of the union appears once, in descending order, with nothing dropped or repeated across long runs with random gaps on all three handshakes. The directed steps also fix the exact cycle in which each ready and each output appears.

// File: rtl/smrg_pkg.sv
`timescale 1ns/1ps
package smrg_pkg;

  // Which heads an output transfer consumes; bit 0 is A, bit 1 is B.
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_BOTH = 2'b11
  } sel_e;

  localparam int NUM_IN = 2;

endpackage

// File: rtl/smrg_rst_sync.sv
`timescale 1ns/1ps
module smrg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release after STAGES clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/smrg_head.sv
`timescale 1ns/1ps
module smrg_head #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic         head_valid,
  output logic [W-1:0] head_data
);

  logic         v_q, v_d;
  logic [W-1:0] d_q;
  logic         load;

  // Next-state logic: refill when empty or when consumed this cycle.
  always_comb begin
    in_ready = rst_n & (!v_q | take);
    load     = in_valid & in_ready;
    v_d      = v_q;
    if (load) begin
      v_d = 1'b1;
    end else if (take) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_d;
    end
  end

  // Data register: no reset, written only on load.
  always_ff @(posedge clk) begin
    if (load) begin
      d_q <= in_data;
    end
  end

  assign head_valid = v_q;
  assign head_data  = d_q;

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid && !take |=> head_valid && $stable(head_data)); // R7

  AST_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> head_valid); // R2

endmodule

// File: rtl/smrg_cmp.sv
`timescale 1ns/1ps
module smrg_cmp
  import smrg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         ha_valid,
  input  logic [W-1:0] ha_data,
  input  logic         hb_valid,
  input  logic [W-1:0] hb_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         take_a,
  output logic         take_b
);

  sel_e sel;
  logic fire;

  always_comb begin
    if (!(ha_valid && hb_valid)) begin
      sel = SEL_NONE;
    end else if (ha_data > hb_data) begin
      sel = SEL_A;
    end else if (ha_data < hb_data) begin
      sel = SEL_B;
    end else begin
      sel = SEL_BOTH;
    end
    out_valid = (sel != SEL_NONE);
    out_data  = (sel == SEL_B) ? hb_data : ha_data;
    fire      = out_valid & out_ready;
    take_a    = fire & sel[0];
    take_b    = fire & sel[1];
  end

endmodule

// File: rtl/sorted_merge_dedup.sv
`timescale 1ns/1ps
module sorted_merge_dedup
  import smrg_pkg::*;
#(
  parameter int W          = 16,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_valid,
  input  logic [W-1:0] a_data,
  output logic         a_ready,
  input  logic         b_valid,
  input  logic [W-1:0] b_data,
  output logic         b_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  logic                     rst_s;
  logic [NUM_IN-1:0]        in_v, in_rdy, take, hv;
  logic [NUM_IN-1:0][W-1:0] in_d, hd;

  smrg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  assign in_v = {b_valid, a_valid};
  assign in_d = {b_data, a_data};

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_head
    smrg_head #(.W(W)) u_head (
      .clk        (clk),
      .rst_n      (rst_s),
      .in_valid   (in_v[gi]),
      .in_data    (in_d[gi]),
      .in_ready   (in_rdy[gi]),
      .take       (take[gi]),
      .head_valid (hv[gi]),
      .head_data  (hd[gi])
    );
  end

  smrg_cmp #(.W(W)) u_cmp (
    .ha_valid  (hv[0]),
    .ha_data   (hd[0]),
    .hb_valid  (hv[1]),
    .hb_data   (hd[1]),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .take_a    (take[0]),
    .take_b    (take[1])
  );

  assign a_ready = in_rdy[0];
  assign b_ready = in_rdy[1];

  AST_WAIT_BOTH: assert property (@(posedge clk) disable iff (!rst_s)
    !(hv[0] && hv[1]) |-> !out_valid); // R2

  AST_WINNER_MAX: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> (out_data >= hd[0]) && (out_data >= hd[1])); // R3

  AST_NEQ_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && out_ready && (hd[0] != hd[1]) |-> (a_ready != b_ready)); // R4

  AST_EQ_BOTH: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && out_ready && (hd[0] == hd[1]) |-> a_ready && b_ready); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6

endmodule

// File: tb/sorted_merge_dedup_tb.sv
`timescale 1ns/1ps
module sorted_merge_dedup_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_valid, b_valid, out_ready;
  logic [W-1:0] a_data, b_data;
  logic         a_ready, b_ready, out_valid;
  logic [W-1:0] out_data;

  always #4 clk = ~clk;

  sorted_merge_dedup #(.W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_valid   (a_valid),
    .a_data    (a_data),
    .a_ready   (a_ready),
    .b_valid   (b_valid),
    .b_data    (b_data),
    .b_ready   (b_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic         s_ar, s_br, s_ov;
  logic [W-1:0] s_od;

  bit in_a [0:255];
  bit in_b [0:255];
  int a_s [0:256];
  int b_s [0:256];
  int e_s [0:256];
  int a_n, b_n, e_n;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, sample before the rising edge.
  task automatic step(input logic av, input logic [W-1:0] ad,
                      input logic bv, input logic [W-1:0] bd, input logic ordy);
    @(negedge clk);
    a_valid = av; a_data = ad; b_valid = bv; b_data = bd; out_ready = ordy;
    #1;
    s_ar = a_ready; s_br = b_ready; s_ov = out_valid; s_od = out_data;
    @(posedge clk);
  endtask

  // Expected output: descending union, each value once, sentinel 0 last.
  function automatic void build_expect();
    e_n = 0;
    for (int v = 255; v >= 0; v--) begin
      if (in_a[v] || in_b[v]) begin
        e_s[e_n] = v;
        e_n++;
      end
    end
  endfunction

  task automatic run_round(input int dens, input int vgap, input int rgap);
    int ai, bi, oi, cyc;
    a_n = 0; b_n = 0;
    for (int v = 255; v >= 1; v--) begin
      in_a[v] = ($urandom % dens) == 0;
      in_b[v] = ($urandom % dens) == 0;
      if (in_a[v]) begin a_s[a_n] = v; a_n++; end
      if (in_b[v]) begin b_s[b_n] = v; b_n++; end
    end
    in_a[0] = 1'b1; in_b[0] = 1'b1;
    a_s[a_n] = 0; a_n++;
    b_s[b_n] = 0; b_n++;
    build_expect();
    ai = 0; bi = 0; oi = 0; cyc = 0;
    while (oi < e_n && cyc < 20000) begin
      @(negedge clk);
      a_valid   = (ai < a_n) && (vgap == 0 || ($urandom % vgap) != 0);
      a_data    = (ai < a_n) ? W'(a_s[ai]) : '0;
      b_valid   = (bi < b_n) && (vgap == 0 || ($urandom % vgap) != 0);
      b_data    = (bi < b_n) ? W'(b_s[bi]) : '0;
      out_ready = (rgap == 0) || (($urandom % rgap) != 0);
      #1;
      if (a_valid && a_ready) ai++;
      if (b_valid && b_ready) bi++;
      if (out_valid && out_ready) begin
        chk("R8 merged value", int'(out_data), e_s[oi]);
        oi++;
      end
      cyc++;
    end
    chk("R8 output count", oi, e_n);
    step(0, '0, 0, '0, 1);
    step(0, '0, 0, '0, 1);
    chk("R8 no extra output", int'(s_ov), 0);
  endtask

  initial begin
    void'($urandom(32'd11));
    rst_n = 1'b0;
    a_valid = 1'b1; a_data = 16'd5; b_valid = 1'b1; b_data = 16'd5; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: empty after reset
    step(0, '0, 0, '0, 0);
    chk("R1 out_valid", int'(s_ov), 0);
    chk("R1 a_ready", int'(s_ar), 1);
    chk("R1 b_ready", int'(s_br), 1);

    // R2: one side alone does not produce output
    step(1, 16'd40, 0, '0, 1);
    chk("R2 a accepted", int'(s_ar), 1);
    step(0, '0, 0, '0, 1);
    chk("R2 no output with A only", int'(s_ov), 0);
    chk("R7 a_ready low when head full", int'(s_ar), 0);
    chk("R2 b_ready still high", int'(s_br), 1);

    // R3 and R6: A=40 beats B=30
    step(0, '0, 1, 16'd30, 1);
    chk("R2 no output before B loads", int'(s_ov), 0);
    step(0, '0, 0, '0, 0);
    chk("R3 out_valid", int'(s_ov), 1);
    chk("R3 out_data", int'(s_od), 40);
    chk("R7 a_ready low when stalled", int'(s_ar), 0);
    chk("R7 b_ready low when stalled", int'(s_br), 0);
    step(0, '0, 0, '0, 0);
    chk("R6 valid held", int'(s_ov), 1);
    chk("R6 data held", int'(s_od), 40);
    step(0, '0, 0, '0, 1);
    chk("R3 a consumed", int'(s_ar), 1);
    chk("R3 b kept", int'(s_br), 0);
    step(0, '0, 0, '0, 1);
    chk("R3 output gone after A consumed", int'(s_ov), 0);

    // R4: B=30 beats A=20
    step(1, 16'd20, 0, '0, 1);
    step(0, '0, 0, '0, 1);
    chk("R4 out_data", int'(s_od), 30);
    chk("R4 b consumed", int'(s_br), 1);
    chk("R4 a kept", int'(s_ar), 0);

    // R5: equal heads 20/20
    step(0, '0, 1, 16'd20, 1);
    step(0, '0, 0, '0, 1);
    chk("R5 out_data", int'(s_od), 20);
    chk("R5 a consumed", int'(s_ar), 1);
    chk("R5 b consumed", int'(s_br), 1);
    step(0, '0, 0, '0, 1);
    chk("R5 emitted once", int'(s_ov), 0);

    // R8: random streams with varying gaps
    run_round(2, 0, 0);
    run_round(3, 3, 4);
    run_round(2, 2, 2);
    run_round(5, 4, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule